// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block gathers the data bytes of one write transaction into a 64-entry page buffer. It then copies them into a storage array as one self-timed commit. The serial protocol engine in front of it does three things. It loads the transaction's start address, it pulses a strobe for each received data byte, and it reports a valid STOP. While the commit runs, the block raises a busy flag for a fixed number of clock cycles. The protocol engine uses that flag to withhold acknowledges, so no request is serviced until busy drops.

The low address bits select a slot inside the page, and they advance after every byte. The high bits name the page and stay fixed for the whole transaction. A protect input decides what a STOP does. When protect is high, the STOP throws the gathered bytes away. When protect is low, the STOP commits them. During the commit, the block steps through the page slots in ascending order. It writes only the slots that received a byte and leaves every other location of the array untouched. The busy window lasts `PROG_CYCLES` clocks; the default equals 10 ms at 125 MHz, and a bench can shorten it.

Top module: `page_write_commit`

## Requirements
- R1: A byte strobe stores `byte_data` at in-page offset `pointer[5:0]` and then increments the offset modulo 64; bits above the offset keep the value loaded by `addr_load`; `addr_load` also empties the buffer.
- R2: A byte that lands on an offset already filled in the same transaction replaces the earlier byte there.
- R3: A commit starts only on `stop_seen` while not busy, with at least one byte buffered and `wp` low.
- R4: `busy` rises on the clock edge that samples the starting `stop_seen` and then stays high for exactly `PROG_CYCLES` consecutive cycles.
- R5: During a commit, `arr_we` pulses once for each filled offset, in ascending offset order, with `arr_addr` = {page bits, offset} and `arr_wdata` = the last byte stored there; `arr_we` is never high while `busy` is low.
- R6: While `busy` is high, `addr_load`, `byte_stb` and `stop_seen` have no effect on the buffer, the address or the commit.
- R7: A `stop_seen` that arrives while `wp` is high never raises `busy` and never writes the array, and it discards the buffered bytes.
- R8: After reset, `busy` and `arr_we` are low and the buffer is empty.
- R9: A `stop_seen` with no byte buffered leaves `busy` low and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_load | input | 1 | Load the start address and empty the buffer |
| start_addr | input | 14 | Start address of the transaction |
| byte_stb | input | 1 | One received data byte |
| byte_data | input | 8 | Data byte qualified by byte_stb |
| stop_seen | input | 1 | A valid STOP ended the write sequence |
| wp | input | 1 | Write protect; high blocks the commit |
| arr_we | output | 1 | Array write enable, one cycle per location |
| arr_addr | output | 14 | Array write address |
| arr_wdata | output | 8 | Array write data |
| busy | output | 1 | Commit in progress; suppress acknowledges |

## Verification
A wrong slot pointer puts data at a wrong `arr_addr` during the commit, so it becomes visible once the STOP has started the commit. It does not show while the bytes are being received. A stale or missing fill flag adds or drops an `arr_we` pulse within the first 64 cycles after the STOP. A wrong busy counter lengthens or shortens the busy window, and the edge where `busy` falls shows it. A lapse in protect or in the busy gating appears as an unexpected `busy` rise on the cycle right after the STOP, or as an extra commit after the window ends.

// File: rtl/pwb_pkg.sv
// Shared constants and helpers for the page write buffer.
// Assumes: page size is a power of two.
package pwb_pkg;
    localparam int DEF_ADDR_W      = 14;
    localparam int DEF_DATA_W      = 8;
    localparam int DEF_PAGE_BYTES  = 64;
    localparam int DEF_PROG_CYCLES = 1_250_000;   // 10 ms at 125 MHz

    typedef enum logic [1:0] {
        CMD_NONE    = 2'd0,
        CMD_COMMIT  = 2'd1,
        CMD_DISCARD = 2'd2
    } stop_cmd_e;

    // Decide what an arriving STOP does.
    function automatic stop_cmd_e decode_stop(input logic stop, input logic busy,
                                              input logic filled, input logic prot);
        if (!stop || busy)  return CMD_NONE;
        if (prot)           return CMD_DISCARD;
        if (filled)         return CMD_COMMIT;
        return CMD_NONE;
    endfunction
endpackage

// File: rtl/pwb_page_store.sv
// Page buffer: holds one page of bytes plus a fill flag per slot, the
// page-number bits and the in-page pointer. Assumes PAGE_BYTES is a power of two.
module pwb_page_store #(
    parameter int ADDR_W     = 14,
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 64,
    localparam int OFF_W     = $clog2(PAGE_BYTES),
    localparam int BASE_W    = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              stb,
    input  logic [DATA_W-1:0] data,
    input  logic              clear,
    input  logic [OFF_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_filled,
    output logic              any_filled,
    output logic [BASE_W-1:0] base
);
    logic [DATA_W-1:0]     slots [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] filled_q;
    logic [OFF_W-1:0]      ptr_q;
    logic [BASE_W-1:0]     base_q;

    // Address register: page bits and in-page pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            base_q <= '0;
        end else if (!hold) begin
            if (load) begin
                ptr_q  <= load_addr[OFF_W-1:0];
                base_q <= load_addr[ADDR_W-1:OFF_W];
            end else if (stb) begin
                ptr_q  <= ptr_q + 1'b1;
            end
        end
    end

    // Fill flags: set per written slot, cleared on load, commit end or discard.
    always_ff @(posedge clk) begin
        if (!rst_n)
            filled_q <= '0;
        else if (clear)
            filled_q <= '0;
        else if (!hold) begin
            if (load)
                filled_q <= '0;
            else if (stb)
                filled_q[ptr_q] <= 1'b1;
        end
    end

    // Data slots: no reset needed, guarded by the fill flags.
    always_ff @(posedge clk) begin
        if (!hold && !load && stb)
            slots[ptr_q] <= data;
    end

    assign rd_data    = slots[rd_idx];
    assign rd_filled  = filled_q[rd_idx];
    assign any_filled = |filled_q;
    assign base       = base_q;

    assert_ptr_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !load && stb && ptr_q == OFF_W'(PAGE_BYTES-1)) |=> (ptr_q == '0));
    assert_base_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(base_q));
    assert_filled_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !clear) |=> $stable(filled_q));
endmodule

// File: rtl/pwb_commit_timer.sv
// Commit timer: holds busy for PROG_CYCLES clocks from a start pulse and
// sweeps the slot index 0..PAGE_BYTES-1 in the first cycles of that window.
// Assumes PROG_CYCLES >= PAGE_BYTES so the sweep ends inside the busy window.
module pwb_commit_timer #(
    parameter int PAGE_BYTES  = 64,
    parameter int PROG_CYCLES = 1_250_000,
    localparam int OFF_W      = $clog2(PAGE_BYTES),
    localparam int CNT_W      = $clog2(PROG_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             busy,
    output logic             sweep_on,
    output logic [OFF_W-1:0] sweep_idx,
    output logic             sweep_end
);
    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;
    logic             sweep_q;
    logic [OFF_W-1:0] idx_q;

    // Busy window counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (start && !busy_q) begin
            busy_q <= 1'b1;
            cnt_q  <= CNT_W'(PROG_CYCLES - 1);
        end else if (busy_q) begin
            if (cnt_q == '0) busy_q <= 1'b0;
            else             cnt_q  <= cnt_q - 1'b1;
        end
    end

    // Slot sweep that drives the array writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sweep_q <= 1'b0;
            idx_q   <= '0;
        end else if (start && !busy_q) begin
            sweep_q <= 1'b1;
            idx_q   <= '0;
        end else if (sweep_q) begin
            if (idx_q == OFF_W'(PAGE_BYTES-1)) sweep_q <= 1'b0;
            idx_q <= idx_q + 1'b1;
        end
    end

    assign busy      = busy_q;
    assign sweep_on  = sweep_q;
    assign sweep_idx = idx_q;
    assign sweep_end = sweep_q && (idx_q == OFF_W'(PAGE_BYTES-1));

    assert_busy_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_q) |-> $past(start));
    assert_sweep_in_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sweep_q |-> busy_q);
endmodule

// File: rtl/page_write_commit.sv
// Page write buffer with self-timed commit. Collects data bytes of one write
// transaction, and on a STOP either commits the filled slots to the array
// (busy for PROG_CYCLES clocks) or discards them under write protect.
// Assumes the protocol engine withholds acknowledges while busy is high.
module page_write_commit #(
    parameter int ADDR_W      = pwb_pkg::DEF_ADDR_W,
    parameter int DATA_W      = pwb_pkg::DEF_DATA_W,
    parameter int PAGE_BYTES  = pwb_pkg::DEF_PAGE_BYTES,
    parameter int PROG_CYCLES = pwb_pkg::DEF_PROG_CYCLES,
    localparam int OFF_W      = $clog2(PAGE_BYTES),
    localparam int BASE_W     = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              byte_stb,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              stop_seen,
    input  logic              wp,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_wdata,
    output logic              busy
);
    import pwb_pkg::*;

    logic              busy_w, sweep_on, sweep_end, rd_filled, any_filled;
    logic [OFF_W-1:0]  sweep_idx;
    logic [DATA_W-1:0] rd_data;
    logic [BASE_W-1:0] base;
    stop_cmd_e         cmd;

    // Classify the STOP against busy, fill state and protect.
    always_comb cmd = decode_stop(stop_seen, busy_w, any_filled, wp);

    pwb_page_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES)) u_store (
        .clk(clk), .rst_n(rst_n), .hold(busy_w),
        .load(addr_load), .load_addr(start_addr),
        .stb(byte_stb), .data(byte_data),
        .clear(sweep_end || cmd == CMD_DISCARD),
        .rd_idx(sweep_idx), .rd_data(rd_data), .rd_filled(rd_filled),
        .any_filled(any_filled), .base(base)
    );

    pwb_commit_timer #(.PAGE_BYTES(PAGE_BYTES), .PROG_CYCLES(PROG_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(cmd == CMD_COMMIT),
        .busy(busy_w), .sweep_on(sweep_on), .sweep_idx(sweep_idx), .sweep_end(sweep_end)
    );

    assign arr_we    = sweep_on && rd_filled;
    assign arr_addr  = {base, sweep_idx};
    assign arr_wdata = rd_data;
    assign busy      = busy_w;

    assert_we_in_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy);
    assert_wp_no_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_seen && wp && !busy) |=> !busy);
    assert_empty_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_seen && !busy && !any_filled) |=> !busy);
    assert_commit_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_seen && !busy && !wp && any_filled) |=> busy);
endmodule

// File: tb/tb_page_write_commit.sv
// Directed bench: one task per scenario, each checking its own results.
module tb_page_write_commit;
    localparam int PROG = 100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        addr_load = 1'b0;
    logic [13:0] start_addr = '0;
    logic        byte_stb = 1'b0;
    logic [7:0]  byte_data = '0;
    logic        stop_seen = 1'b0;
    logic        wp = 1'b0;
    logic        arr_we;
    logic [13:0] arr_addr;
    logic [7:0]  arr_wdata;
    logic        busy;

    int n_chk = 0, n_bad = 0;
    int log_n = 0, busy_n = 0;
    logic [13:0] log_a [256];
    logic [7:0]  log_d [256];

    page_write_commit #(.PROG_CYCLES(PROG)) dut (.*);

    always #4 clk = ~clk;   // 125 MHz

    // Monitor: record array writes and busy cycles away from the active edge.
    always @(negedge clk) begin
        if (arr_we && log_n < 256) begin
            log_a[log_n] = arr_addr;
            log_d[log_n] = arr_wdata;
            log_n++;
        end
        if (busy) busy_n++;
    end

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic load(logic [13:0] a);
        @(negedge clk); addr_load = 1'b1; start_addr = a;
        @(negedge clk); addr_load = 1'b0;
    endtask

    task automatic put(logic [7:0] d);
        @(negedge clk); byte_stb = 1'b1; byte_data = d;
        @(negedge clk); byte_stb = 1'b0;
    endtask

    // STOP pulse; returns busy as seen one cycle later.
    task automatic stop(output logic b);
        @(negedge clk); stop_seen = 1'b1;
        @(negedge clk); stop_seen = 1'b0; b = busy;
    endtask

    task automatic settle;
        repeat (PROG + 10) @(negedge clk);
    endtask

    task automatic clear_log;
        log_n = 0; busy_n = 0;
    endtask

    task automatic t_reset;
        chk("R8 busy after reset", busy, 0);
        chk("R8 we after reset", arr_we, 0);
        begin logic b; clear_log(); stop(b); chk("R8 empty buffer stop", b, 0); end
        settle(); chk("R8 no writes", log_n, 0);
    endtask

    task automatic t_byte;
        logic b;
        clear_log(); load(14'h1234); put(8'hA5); stop(b);
        chk("R4 busy next cycle", b, 1);
        settle();
        chk("R4 busy length", busy_n, PROG);
        chk("R3 one write", log_n, 1);
        chk("R5 addr", log_a[0], 14'h1234);
        chk("R5 data", log_d[0], 8'hA5);
    endtask

    task automatic t_page;
        logic b;
        clear_log(); load(14'h00C0);
        for (int i = 0; i < 64; i++) put(8'(i) ^ 8'h5A);
        stop(b); settle();
        chk("R5 full page count", log_n, 64);
        for (int i = 0; i < 64; i++) begin
            chk("R1 page addr", log_a[i], 14'h00C0 + i);
            chk("R5 page data", log_d[i], 8'(i) ^ 8'h5A);
        end
    endtask

    task automatic t_wrap;
        logic b;
        clear_log(); load(14'h02FE);
        put(8'hD0); put(8'hD1); put(8'hD2); put(8'hD3);
        stop(b); settle();
        chk("R1 wrap count", log_n, 4);
        chk("R1 wrap a0", log_a[0], 14'h02C0); chk("R1 wrap d0", log_d[0], 8'hD2);
        chk("R1 wrap a1", log_a[1], 14'h02C1); chk("R1 wrap d1", log_d[1], 8'hD3);
        chk("R1 wrap a2", log_a[2], 14'h02FE); chk("R1 wrap d2", log_d[2], 8'hD0);
        chk("R1 wrap a3", log_a[3], 14'h02FF); chk("R1 wrap d3", log_d[3], 8'hD1);
    endtask

    task automatic t_overflow;
        logic b;
        clear_log(); load(14'h0100);
        for (int i = 0; i < 66; i++) put(8'(i + 1));
        stop(b); settle();
        chk("R2 count", log_n, 64);
        chk("R2 slot0 replaced", log_d[0], 65);
        chk("R2 slot1 replaced", log_d[1], 66);
        chk("R2 slot2 kept", log_d[2], 3);
    endtask

    task automatic t_empty_and_reload;
        logic b;
        clear_log(); load(14'h0040); stop(b);
        chk("R9 no busy", b, 0);
        settle(); chk("R9 no writes", log_n, 0);
        clear_log(); load(14'h0040); put(8'h11); load(14'h0080); put(8'h22); stop(b); settle();
        chk("R1 load empties count", log_n, 1);
        chk("R1 reload addr", log_a[0], 14'h0080);
        chk("R1 reload data", log_d[0], 8'h22);
    endtask

    task automatic t_protect;
        logic b;
        clear_log(); load(14'h0010); put(8'h33); put(8'h44);
        wp = 1'b1; stop(b); wp = 1'b0;
        chk("R7 no busy", b, 0);
        stop(b); settle();
        chk("R7 discarded, no busy", busy_n, 0);
        chk("R7 no writes", log_n, 0);
    endtask

    task automatic t_busy_ignore;
        logic b;
        clear_log(); load(14'h0200); put(8'h55); stop(b);
        load(14'h0300); put(8'h77); stop(b);
        chk("R6 still busy", busy, 1);
        settle();
        chk("R6 busy length", busy_n, PROG);
        chk("R6 single write", log_n, 1);
        chk("R6 addr unchanged", log_a[0], 14'h0200);
        clear_log(); stop(b); settle();
        chk("R6 ignored byte not stored", log_n, 0);
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_byte();
        t_page();
        t_wrap();
        t_overflow();
        t_empty_and_reload();
        t_protect();
        t_busy_ignore();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule